// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Flags

A first-in first-out buffer for 9-bit words, written on one clock and read on another. Each port has an active-low enable. An active-low master reset empties it. The fill level is reported as a 2-bit code. The read side owns the "empty" and "almost empty" parts of that code, and the write side owns the "almost full" part. Each part is refreshed only on its own clock's rising edges.

Pointers cross between the clock domains as Gray codes through two-flop synchronizers. An event on the opposite clock therefore reaches a flag only after two edges of the flag's own clock. When the read side shows empty while words are present, the next read edge only refreshes the code: it moves no data, whatever the read enable is. A parameter declares that both clock ports are driven by one clock. The synchronizers are then removed, and a write and a read on the same edge are both counted in the flag update.

Top module: `dcf_fifo`

## Requirements
- R1: Words come out of `rd_data` in the order they were accepted, all WIDTH bits intact. `rd_data` is registered and changes on the enabled read edge that consumes the word.
- R2: `state_code` is 2'b00 for empty (0 words seen), 2'b10 for 1 to ALMOST words, 2'b11 for intermediate, and 2'b01 when at most ALMOST free locations remain (DEPTH-ALMOST words or more). The empty and low codes take priority over the high code.
- R3: The empty and almost-empty parts change only on read-clock edges. A write is first counted on the third read edge after it, so writes into an empty buffer leave the code at 2'b00 until then.
- R4: While the read side shows empty, a read edge moves no data and leaves `rd_data` unchanged, whatever `rd_en_n` is. If words are present, that edge updates the code.
- R5: Out of the low or intermediate states, a read edge with `rd_en_n` low reads a word and updates the code in the same edge. With `rd_en_n` high, it only updates the code.
- R6: The almost-full part changes only on write-clock edges. After reads drain the buffer below the threshold, the code keeps 2'b01 until a write edge refreshes it, even an edge with `wr_en_n` high. A read is counted on the third write edge after it.
- R7: A write attempted while the buffer is full is discarded. The word never appears at the output.
- R8: A read attempted while empty is discarded, and `rd_data` keeps the last word actually read.
- R9: An enabled read of the last word drives `state_code` to 2'b00 on that same edge.
- R10: While `rst_n` is low, `state_code` is 2'b00 and `rd_data` is zero. Reset release is synchronized separately into each clock domain.
- R11: With SHARED_CLK=1 and both clock ports on one clock, an edge that both writes and reads keeps the count and the code steady, and still delivers data in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read clock (tie to wr_clk when SHARED_CLK=1) |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | WIDTH | Registered output word |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| state_code | output | 2 | Fill-level code: 00 empty, 10 low, 11 intermediate, 01 high |

## Verification
The hardest states to reach are those where one half of the code is stale. These are an empty code with words present, which needs a latent read edge, and a high code that persists after reads. Free-running clocks would refresh both halves at once and hide the stale state. The bench therefore drives each clock as individual pulses, so it can run many edges of one clock while the other stands still. This reaches the stale codes on purpose, and the bench then checks the exact edge that refreshes them, with the enable both high and low. A small depth lets the bench step the fill level through every count from empty to full and back, with one word per step.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Read-side fill level as seen by the read clock.
  typedef enum logic [1:0] {
    LVL_EMPTY = 2'd0,
    LVL_LOW   = 2'd1,
    LVL_MID   = 2'd2
  } rd_lvl_e;

  // Output code: 00 empty, 10 low, 11 intermediate, 01 high.
  function automatic logic [1:0] code_of(input rd_lvl_e lvl, input logic high);
    case (lvl)
      LVL_EMPTY: return 2'b00;
      LVL_LOW:   return 2'b10;
      default:   return high ? 2'b01 : 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int DEPTH  = 512,
  parameter int ALMOST = 16,
  parameter int SHARED = 0,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [PW-1:0] peer_gray,
  input  logic          peer_go,
  output logic          go,
  output logic [AW-1:0] addr,
  output logic [PW-1:0] gray_q,
  output logic          high_q
);
  logic [PW-1:0] bin_q, bin_d, peer_bin, used, used_nx;
  logic          full_q, full_d, high_d, peer_inc;

  assign peer_inc = (SHARED != 0) && peer_go;
  assign addr     = bin_q[AW-1:0];

  always_comb begin
    for (int i = 0; i < PW; i++) peer_bin[i] = ^(peer_gray >> i);
    used    = bin_q - peer_bin;
    go      = !en_n && !full_q;
    used_nx = used + PW'(go) - PW'(peer_inc);
    bin_d   = bin_q + PW'(go);
    full_d  = (used_nx == PW'(DEPTH));
    high_d  = (used_nx >= PW'(DEPTH - ALMOST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      full_q <= 1'b0;
      high_q <= 1'b0;
    end else begin
      if (go) begin
        bin_q  <= bin_d;
        gray_q <= bin_d ^ (bin_d >> 1);
      end
      full_q <= full_d;
      high_q <= high_d;
    end
  end

  // R7: an accepted write never pushes the occupancy past the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (used < PW'(DEPTH)));

  // R7: the write pointer stays put on an edge where the buffer was full
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> (bin_q == $past(bin_q)));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 512,
  parameter int ALMOST = 16,
  parameter int SHARED = 0,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_n,
  input  logic [PW-1:0]       peer_gray,
  input  logic                peer_go,
  input  logic [WIDTH-1:0]    rdata,
  output logic                go,
  output logic [AW-1:0]       addr,
  output logic [PW-1:0]       gray_q,
  output dcf_pkg::rd_lvl_e    lvl_q,
  output logic [WIDTH-1:0]    data_q
);
  import dcf_pkg::*;

  logic [PW-1:0] bin_q, bin_d, peer_bin, used, used_nx;
  logic          peer_inc;
  rd_lvl_e       lvl_d;

  assign peer_inc = (SHARED != 0) && peer_go;
  assign addr     = bin_q[AW-1:0];

  always_comb begin
    for (int i = 0; i < PW; i++) peer_bin[i] = ^(peer_gray >> i);
    used    = peer_bin - bin_q;
    go      = !en_n && (lvl_q != LVL_EMPTY);
    used_nx = used - PW'(go) + PW'(peer_inc);
    bin_d   = bin_q + PW'(go);
    if (used_nx == '0)                 lvl_d = LVL_EMPTY;
    else if (used_nx <= PW'(ALMOST))   lvl_d = LVL_LOW;
    else                               lvl_d = LVL_MID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      lvl_q  <= LVL_EMPTY;
      data_q <= '0;
    end else begin
      if (go) begin
        bin_q  <= bin_d;
        gray_q <= bin_d ^ (bin_d >> 1);
        data_q <= rdata;
      end
      lvl_q <= lvl_d;
    end
  end

  // R8: a read is only taken while words are really present
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (used != '0));

  // R4: a latent edge moves no pointer
  a_r4_latent_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_EMPTY) |=> (bin_q == $past(bin_q)));

  // R4: a latent edge keeps the output word
  a_r4_latent_data: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_EMPTY) |=> $stable(data_q));

  // R9: taking the last word shows empty at once
  a_r9_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    (go && used == PW'(1) && !peer_inc) |=> (lvl_q == LVL_EMPTY));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int WIDTH      = 9,
  parameter int DEPTH      = 512,
  parameter int ALMOST     = 16,
  parameter int SHARED_CLK = 0
) (
  input  logic             wr_clk,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rst_n,
  output logic [1:0]       state_code
);
  import dcf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             wrst_n, rrst_n;
  logic             w_go, r_go, w_high;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wgray_at_r, rgray_at_w;
  logic [WIDTH-1:0] mem_q [DEPTH];
  rd_lvl_e          r_lvl;

  dcf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  generate
    if (SHARED_CLK != 0) begin : g_direct
      assign wgray_at_r = wgray;
      assign rgray_at_w = rgray;
    end else begin : g_cdc
      dcf_ptr_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r));
      dcf_ptr_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w));
    end
  endgenerate

  dcf_wr_side #(.DEPTH(DEPTH), .ALMOST(ALMOST), .SHARED(SHARED_CLK)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .en_n(wr_en_n), .peer_gray(rgray_at_w), .peer_go(r_go),
    .go(w_go), .addr(waddr), .gray_q(wgray), .high_q(w_high));

  dcf_rd_side #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ALMOST(ALMOST), .SHARED(SHARED_CLK)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .en_n(rd_en_n), .peer_gray(wgray_at_r), .peer_go(w_go),
    .rdata(mem_q[raddr]), .go(r_go), .addr(raddr), .gray_q(rgray), .lvl_q(r_lvl),
    .data_q(rd_data));

  always_ff @(posedge wr_clk) begin
    if (w_go) mem_q[waddr] <= wr_data;
  end

  assign state_code = code_of(r_lvl, w_high);

  // R10: reset shows empty with a cleared output
  a_r10_reset_state: assert property (@(posedge rd_clk)
    !rst_n |-> (state_code == 2'b00 && rd_data == '0));
endmodule

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;
  localparam int W = 9;
  localparam int D = 32;
  localparam int A = 4;

  logic         wck, rck, sck, rst_n;
  logic         wen_n, ren_n, sw_n, sr_n;
  logic [W-1:0] wd, rq, sd, sq;
  logic [1:0]   code, scode;

  int total = 0;
  int bad   = 0;
  int nw    = 0;
  logic [W-1:0] mdl [$];
  logic [W-1:0] smdl [$];
  logic [W-1:0] e, last;

  dcf_fifo #(.WIDTH(W), .DEPTH(D), .ALMOST(A), .SHARED_CLK(0)) i_dcf_fifo (
    .wr_clk(wck), .wr_en_n(wen_n), .wr_data(wd), .rd_clk(rck), .rd_en_n(ren_n),
    .rd_data(rq), .rst_n(rst_n), .state_code(code));

  dcf_fifo #(.WIDTH(W), .DEPTH(D), .ALMOST(A), .SHARED_CLK(1)) i_dcf_fifo_one (
    .wr_clk(sck), .wr_en_n(sw_n), .wr_data(sd), .rd_clk(sck), .rd_en_n(sr_n),
    .rd_data(sq), .rst_n(rst_n), .state_code(scode));

  function automatic logic [1:0] exp_code(input int seen, input bit high);
    if (seen == 0) return 2'b00;
    if (seen <= A) return 2'b10;
    if (high)      return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [W-1:0] pat(input int n);
    return W'((n * 37 + 11) % 512);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wp(input logic en_n, input logic [W-1:0] d);
    wen_n = en_n; wd = d;
    #2 wck = 1'b1;
    #5 wck = 1'b0;
    #3;
  endtask

  task automatic rp(input logic en_n);
    ren_n = en_n;
    #2 rck = 1'b1;
    #5 rck = 1'b0;
    #3;
  endtask

  task automatic sp(input logic wn, input logic rn, input logic [W-1:0] d);
    sw_n = wn; sr_n = rn; sd = d;
    #2 sck = 1'b1;
    #5 sck = 1'b0;
    #3;
  endtask

  task automatic push_word();
    wp(1'b0, pat(nw));
    mdl.push_back(pat(nw));
    nw++;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wck = 0; rck = 0; sck = 0;
    wen_n = 1; ren_n = 1; sw_n = 1; sr_n = 1; wd = '0; sd = '0;
    rst_n = 0;
    repeat (2) begin wp(1, '0); rp(1); sp(1, 1, '0); end
    // R10: state during reset
    chk("R10 code in reset", 32'(code), 32'(2'b00));
    chk("R10 data in reset", 32'(rq), 0);
    chk("R10 shared code in reset", 32'(scode), 32'(2'b00));
    rst_n = 1;
    repeat (3) begin wp(1, '0); rp(1); sp(1, 1, '0); end
    chk("R10 code after release", 32'(code), 32'(2'b00));
    chk("R10 data after release", 32'(sq), 0);

    // R3 / R4: writes into empty, latent edge, then data
    repeat (3) push_word();
    chk("R3 empty shown after writes", 32'(code), 32'(2'b00));
    rp(1); rp(1);
    chk("R3 still empty before sync", 32'(code), 32'(2'b00));
    rp(0);
    chk("R4 latent edge updates code", 32'(code), 32'(2'b10));
    chk("R4 latent edge moves no data", 32'(rq), 0);
    for (int i = 0; i < 3; i++) begin
      e = mdl.pop_front();
      rp(0);
      chk("R1 order after latent", 32'(rq), 32'(e));
    end
    last = e;
    chk("R9 last word empties at once", 32'(code), 32'(2'b00));
    rp(0);
    chk("R8 empty read holds output", 32'(rq), 32'(last));
    chk("R8 empty read keeps code", 32'(code), 32'(2'b00));

    // R2 sweep: fill one word at a time, empty up to full
    for (int k = 1; k <= D; k++) begin
      push_word();
      chk((k == D - A) ? "R6 high set on write edge" : "R3 read half stale after write",
          32'(code), 32'(exp_code(k - 1, k >= D - A)));
      rp(1); rp(1); rp(1);
      chk((k == A + 1) ? "R5 update with enable high" : "R2 code at fill level",
          32'(code), 32'(exp_code(k, k >= D - A)));
    end

    // R7: a write while full is dropped
    wp(1'b0, 9'h1FF);
    chk("R7 full code after dropped write", 32'(code), 32'(2'b01));
    rp(1); rp(1); rp(1);
    chk("R7 no extra word after sync", 32'(code), 32'(2'b01));

    // drain sweep; high half stays until write edges refresh it (R6)
    begin
      bit hi = 1'b1;
      for (int c = D - 1; c >= 0; c--) begin
        e = mdl.pop_front();
        rp(0);
        chk("R1 drain order", 32'(rq), 32'(e));
        chk("R6 code while draining", 32'(code), 32'(exp_code(c, hi)));
        if (c == D - A - 2) begin
          wp(1, '0); wp(1, '0);
          chk("R6 high held until sync", 32'(code), 32'(2'b01));
          wp(1, '0);
          hi = 1'b0;
          chk("R6 high cleared by idle write edge", 32'(code), 32'(2'b11));
        end
      end
    end
    chk("R9 empty after full drain", 32'(code), 32'(2'b00));
    rp(1); rp(1); rp(0);
    chk("R7 dropped word never read", 32'(rq), 32'(e));
    chk("R7 buffer empty after drain", 32'(code), 32'(2'b00));

    // R5: low to intermediate on an enabled read edge
    wp(1, '0); wp(1, '0);
    repeat (4) push_word();
    rp(1); rp(1); rp(1);
    chk("R4 latent with enable high", 32'(code), 32'(2'b10));
    repeat (2) push_word();
    rp(1); rp(1);
    chk("R3 low held before sync", 32'(code), 32'(2'b10));
    e = mdl.pop_front();
    rp(0);
    chk("R5 enabled update reads word", 32'(rq), 32'(e));
    chk("R5 enabled update code", 32'(code), 32'(2'b11));
    while (mdl.size() > 0) begin
      e = mdl.pop_front();
      rp(0);
      chk("R1 order after enabled update", 32'(rq), 32'(e));
    end
    chk("R9 empty at end", 32'(code), 32'(2'b00));

    // R11: shared clock, simultaneous write and read
    for (int i = 0; i < 5; i++) begin
      sp(0, 1, pat(100 + i));
      smdl.push_back(pat(100 + i));
    end
    chk("R11 shared code after fill", 32'(scode), 32'(2'b11));
    for (int i = 0; i < 10; i++) begin
      e = smdl.pop_front();
      sp(0, 0, pat(200 + i));
      smdl.push_back(pat(200 + i));
      chk("R11 shared data order", 32'(sq), 32'(e));
      chk("R11 shared code steady", 32'(scode), 32'(2'b11));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule